// File: doc/BRIEF.md
# Dual-Line Interrupt Flag Router

This block gathers a vector of single-bit event sources into sticky flag bits and steers them onto two interrupt request outputs. A flag is captured when its source goes from low to high. It then holds until software writes a 1 to its bit. Each flag has a per-bit enable, which decides whether the flag may raise an interrupt at all. Each flag also has a per-bit line-select, which picks the output line it drives. A separate two-bit line-enable register gates each output line as a whole.

Software reaches the block through a small register port with a one-cycle write strobe and a combinational read. The port holds four words: the flags (write-1-to-clear), the enables, the line-selects and the line enables. A configurable range of flag positions is left unimplemented. Those flags always read 0, but their enable and select bits are still stored. The event producers sit outside this block.

Top module: `dual_irq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags, enables, line-selects and line enables are cleared, so both interrupt outputs are low after reset.
- R2: A flag is set at the clock edge where its source input is sampled high after being sampled low at the previous edge (low is assumed during reset). It can be read back from the next cycle on.
- R3: A source held high sets its flag only once. After the flag is cleared, it stays clear while the source remains high.
- R4: Writing address 0 clears every flag whose bit in the write data is 1.
- R5: A 0 bit written to address 0 leaves the corresponding flag unchanged.
- R6: When a rising edge and a write-1 clear hit the same flag at the same edge, the flag ends up set.
- R7: A set flag whose enable bit (address 1) is 0 drives neither interrupt output.
- R8: An enabled, set flag drives `irq_line0` when its line-select bit (address 2) is 0 and `irq_line1` when it is 1. Each output is the level OR of all such flags and drops once they are cleared.
- R9: Bit 0 of the line-enable register (address 3) gates `irq_line0` and bit 1 gates `irq_line1`. An output is low while its enable bit is 0.
- R10: Flag positions in the unimplemented range (default bits 20 and 21) always read 0 and never raise an interrupt, whatever their source does. Their enable and select bits still store and read back.
- R11: Reads return the register selected by `reg_addr`: 0 flags, 1 enables, 2 line-selects, 3 line enables in bits 1:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_SRC | Raw event sources, one per flag |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register select (0 flags, 1 enable, 2 select, 3 line enable) |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data of the selected register |
| irq_line0 | output | 1 | Interrupt output, line 0 |
| irq_line1 | output | 1 | Interrupt output, line 1 |

## Verification
The bench builds the block with its defaults: 30 sources and a two-bit unimplemented gap starting at bit 20. The gap places dead flags between live ones, and the width puts the top flag, bit 29, at the edge of the register. That lets one run show that bits 20 and 21 stay 0 while their neighbours and bit 29 still capture and route. It also shows that the enable and select bits of the gap store normally.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses and the helper that builds the
// mask of implemented flag positions.
package irq_router_pkg;

    typedef enum logic [1:0] {
        RA_FLAGS  = 2'd0,
        RA_ENABLE = 2'd1,
        RA_SELECT = 2'd2,
        RA_LINES  = 2'd3
    } reg_addr_e;

    localparam int NUM_LINES = 2;

    // Ones everywhere except the gap [lo +: w].
    function automatic logic [63:0] impl_mask(input int n, input int lo, input int w);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[i] = !((i >= lo) && (i < lo + w));
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
`timescale 1ns/1ps
// Rising-edge detector for a vector of event sources.
// Assumes sources are synchronous to clk; a source high in the first
// cycle after reset counts as an edge (history resets low).
module irq_edge_detect #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Keep the previous sample of every source.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt;
    end

    // Edge = high now, low last cycle.
    always_comb rise = evt & ~prev_q;
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
// Sticky flag bank: set on detected edge, cleared by write-1.
// Assumes clr is the write-data mask already qualified by the flag
// address. A set and a clear on the same bit leave it set.
module irq_flag_bank #(
    parameter int             W    = 30,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_q;

    // Update flags: clear first, then OR in new edges, drop gap bits.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= ((flags_q & ~clr) | rise) & IMPL;
    end

    assign flags = flags_q;
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
// Configuration registers: per-flag enable, per-flag line select and
// the two line enables. Writes take effect at the strobe's clock edge.
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int W = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [1:0]           addr,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         en,
    output logic [W-1:0]         sel,
    output logic [NUM_LINES-1:0] line_en
);
    logic [W-1:0]         en_q;
    logic [W-1:0]         sel_q;
    logic [NUM_LINES-1:0] line_q;

    // Store the register addressed by a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            sel_q  <= '0;
            line_q <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                RA_ENABLE: en_q   <= wdata;
                RA_SELECT: sel_q  <= wdata;
                RA_LINES:  line_q <= wdata[NUM_LINES-1:0];
                default:   ;
            endcase
        end
    end

    assign en      = en_q;
    assign sel     = sel_q;
    assign line_en = line_q;
endmodule

// File: rtl/irq_line_router.sv
`timescale 1ns/1ps
// Combines enabled, set flags per line and gates each line with its
// own enable. Select bit 0 picks line 0, 1 picks line 1.
module irq_line_router
    import irq_router_pkg::*;
#(
    parameter int W = 30
) (
    input  logic [W-1:0]         flags,
    input  logic [W-1:0]         en,
    input  logic [W-1:0]         sel,
    input  logic [NUM_LINES-1:0] line_en,
    output logic [NUM_LINES-1:0] irq
);
    logic [W-1:0] live;

    // Flags allowed to interrupt at all.
    always_comb live = flags & en;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [W-1:0] pick;
        // Flags steered to this line.
        always_comb pick = (l == 0) ? (live & ~sel) : (live & sel);
        // Level output, gated by the line enable.
        always_comb irq[l] = line_en[l] & (|pick);
    end
endmodule

// File: rtl/dual_irq_router.sv
`timescale 1ns/1ps
// Top: edge capture, sticky flags, configuration and two-line routing.
// Assumes a single clock domain and one register access per cycle.
module dual_irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 30,
    parameter int GAP_LO  = 20,
    parameter int GAP_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_line0,
    output logic               irq_line1
);
    localparam logic [63:0]        MASK64    = impl_mask(NUM_SRC, GAP_LO, GAP_W);
    localparam logic [NUM_SRC-1:0] FLAG_IMPL = MASK64[NUM_SRC-1:0];

    logic [NUM_SRC-1:0]   rise_w;
    logic [NUM_SRC-1:0]   clr_w;
    logic [NUM_SRC-1:0]   flags_w;
    logic [NUM_SRC-1:0]   en_w;
    logic [NUM_SRC-1:0]   sel_w;
    logic [NUM_LINES-1:0] line_en_w;
    logic [NUM_LINES-1:0] irq_w;

    irq_edge_detect #(.W(NUM_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .rise(rise_w)
    );

    // Write-1-to-clear mask for the flag word.
    always_comb clr_w = (reg_wr && reg_addr == RA_FLAGS) ? reg_wdata : '0;

    irq_flag_bank #(.W(NUM_SRC), .IMPL(FLAG_IMPL)) u_flags (
        .clk(clk), .rst_n(rst_n), .rise(rise_w), .clr(clr_w), .flags(flags_w)
    );

    irq_cfg_regs #(.W(NUM_SRC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .en(en_w), .sel(sel_w), .line_en(line_en_w)
    );

    irq_line_router #(.W(NUM_SRC)) u_route (
        .flags(flags_w), .en(en_w), .sel(sel_w), .line_en(line_en_w), .irq(irq_w)
    );

    // Read mux over the four words.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_FLAGS:  reg_rdata = flags_w;
            RA_ENABLE: reg_rdata = en_w;
            RA_SELECT: reg_rdata = sel_w;
            RA_LINES:  reg_rdata[NUM_LINES-1:0] = line_en_w;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_line0 = irq_w[0];
    assign irq_line1 = irq_w[1];
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
// Checker for dual_irq_router, attached by bind below.
module irq_router_chk #(
    parameter int           W    = 30,
    parameter logic [W-1:0] IMPL = '1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] rise,
    input logic [W-1:0] flags,
    input logic [W-1:0] en,
    input logic [W-1:0] sel,
    input logic [1:0]   line_en,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic         irq_line0,
    input logic         irq_line1
);
    // R2
    flag_set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(rise)) == '0));

    // R4
    flag_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> (($past(flags) & ~flags) == '0));

    // R6
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ($past(rise) & IMPL)) == ($past(rise) & IMPL)));

    // R10
    gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~IMPL) == '0);

    // R7
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en) == '0) |-> (!irq_line0 && !irq_line1));

    // R9
    line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_en[0] |-> !irq_line0) and (!line_en[1] |-> !irq_line1));

    // R8
    line1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line1 |-> ((flags & en & sel) != '0));
endmodule

bind dual_irq_router irq_router_chk #(.W(NUM_SRC), .IMPL(FLAG_IMPL)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise(rise_w), .flags(flags_w), .en(en_w),
    .sel(sel_w), .line_en(line_en_w), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_line0(irq_line0), .irq_line1(irq_line1)
);

// File: tb/dual_irq_router_tb.sv
`timescale 1ns/1ps
module dual_irq_router_tb;
    localparam int N = 30;
    localparam logic [N-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_line0;
    logic         irq_line1;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dual_irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_line0(irq_line0), .irq_line1(irq_line1)
    );

    task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic e0, input logic e1, input string tag);
        @(negedge clk);
        #1;
        total++;
        if (irq_line0 !== e0 || irq_line1 !== e1) begin
            bad++;
            $display("FAIL %s irq actual=%b%b expected=%b%b", tag, irq_line1, irq_line0, e1, e0);
        end
    endtask

    task automatic pulse(input int i);
        @(negedge clk); evt[i] = 1'b1;
        @(negedge clk); evt[i] = 1'b0;
    endtask

    task automatic t_reset_state;
        read_chk(2'd0, '0, "R1 flags");
        read_chk(2'd1, '0, "R1 enable");
        read_chk(2'd2, '0, "R1 select");
        read_chk(2'd3, '0, "R1 lines");
        irq_chk(1'b0, 1'b0, "R1 outputs");
    endtask

    task automatic t_edge_set;
        pulse(3);
        read_chk(2'd0, N'(1) << 3, "R2 edge sets flag");
        reg_write(2'd0, ALL);
        read_chk(2'd0, '0, "R4 clear all");
    endtask

    task automatic t_held_level;
        @(negedge clk); evt[5] = 1'b1;
        read_chk(2'd0, N'(1) << 5, "R2 level edge");
        reg_write(2'd0, N'(1) << 5);
        repeat (3) @(negedge clk);
        read_chk(2'd0, '0, "R3 held source no reset");
        @(negedge clk); evt[5] = 1'b0;
    endtask

    task automatic t_write_zero_and_one;
        pulse(7);
        pulse(9);
        reg_write(2'd0, '0);
        read_chk(2'd0, (N'(1) << 7) | (N'(1) << 9), "R5 write zero");
        reg_write(2'd0, N'(1) << 7);
        read_chk(2'd0, N'(1) << 9, "R4 clear one bit");
        reg_write(2'd0, ALL);
    endtask

    task automatic t_collision;
        pulse(2);
        @(negedge clk);
        evt[2] = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = N'(1) << 2;
        @(negedge clk);
        evt[2] = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        read_chk(2'd0, N'(1) << 2, "R6 edge wins over clear");
        reg_write(2'd0, ALL);
    endtask

    task automatic t_routing;
        pulse(4);
        pulse(29);
        reg_write(2'd3, N'(3));
        irq_chk(1'b0, 1'b0, "R7 masked flags silent");
        reg_write(2'd1, N'(1) << 4);
        irq_chk(1'b1, 1'b0, "R8 select0 to line0");
        reg_write(2'd2, N'(1) << 4);
        irq_chk(1'b0, 1'b1, "R8 select1 to line1");
        reg_write(2'd1, (N'(1) << 4) | (N'(1) << 29));
        irq_chk(1'b1, 1'b1, "R8 both lines");
        reg_write(2'd3, N'(2));
        irq_chk(1'b0, 1'b1, "R9 line0 gated");
        reg_write(2'd3, N'(1));
        irq_chk(1'b1, 1'b0, "R9 line1 gated");
        reg_write(2'd3, N'(0));
        irq_chk(1'b0, 1'b0, "R9 both gated");
        reg_write(2'd3, N'(3));
        reg_write(2'd0, N'(1) << 4);
        irq_chk(1'b1, 1'b0, "R8 line1 drops after clear");
        reg_write(2'd0, ALL);
        irq_chk(1'b0, 1'b0, "R8 all cleared");
    endtask

    task automatic t_gap_bits;
        reg_write(2'd1, ALL);
        reg_write(2'd3, N'(3));
        pulse(20);
        pulse(21);
        read_chk(2'd0, '0, "R10 gap flags read zero");
        irq_chk(1'b0, 1'b0, "R10 gap flags no irq");
        reg_write(2'd1, N'(3) << 20);
        read_chk(2'd1, N'(3) << 20, "R10 gap enable stored");
        reg_write(2'd2, N'(3) << 20);
        read_chk(2'd2, N'(3) << 20, "R10 gap select stored");
    endtask

    task automatic t_readback;
        reg_write(2'd1, 30'h1555_5555);
        read_chk(2'd1, 30'h1555_5555, "R11 enable readback");
        reg_write(2'd2, 30'h2AAA_AAAA);
        read_chk(2'd2, 30'h2AAA_AAAA, "R11 select readback");
        reg_write(2'd3, ALL);
        read_chk(2'd3, N'(3), "R11 lines readback");
    endtask

    task automatic t_reset_clears;
        reg_write(2'd1, ALL);
        pulse(1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_chk(2'd0, '0, "R1 reset clears flags");
        read_chk(2'd1, '0, "R1 reset clears enable");
        irq_chk(1'b0, 1'b0, "R1 reset outputs low");
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_edge_set();
        t_held_level();
        t_write_zero_and_one();
        t_collision();
        t_routing();
        t_gap_bits();
        t_readback();
        t_reset_clears();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule